// File: doc/BRIEF.md
# AAL1 Cell Payload Header Checker

This block sits on the receive side of an AAL1 adaptation path. It takes 48-octet cell payloads as a byte stream, with a marker on the first byte of each cell. It checks the protection on the header octet and tracks the 3-bit sequence count from cell to cell. Cells that arrive out of order, are missing, or carry a corrupted header are reported. When a cell carries a structure pointer, the block picks it out and checks it. The 47 payload octets after the header are passed downstream, and the pointer octet is flagged when it is present.

Both streaming interfaces use valid/ready handshakes, and a byte moves when valid and ready are both high at a rising edge. The header octet is always accepted and is never forwarded. A payload octet passes straight from input to output, so when the output is stalled the input is stalled too. A source must keep `in_data` and `in_sop` stable while `in_valid` is high and `in_ready` is low. The per-cell status pins are plain registered levels. They are defined while the last payload octet of a cell is on the output, and they hold until the next header is accepted.

Top module: `aal1_sar_rx`

## Requirements
- R1: The header octet is laid out as bit 7 = cell indication (CI), bits 6:4 = sequence count (SC), bits 3:1 = CRC and bit 0 = parity. `st_hdr_ok` is 1 only if the whole octet has even parity and the CRC equals the remainder of {CI,SC}·x^3 divided by x^3+x+1.
- R2: The header octet is not forwarded. The next 47 octets are forwarded in order with `out_data` equal to the input byte, and `out_last` is high on the 47th. After that octet the block waits for a new header.
- R3: While a header slot is open, `in_ready` is 1. During payload octets `in_ready` equals `out_ready`, so `out_valid && !out_ready` always implies `!in_ready`.
- R4: After each valid header, the expected count becomes SC+1 modulo 8. The first valid header after reset is accepted without a sequence error.
- R5: A valid header whose SC differs from the expected count sets `st_seq_err`, and tracking resumes from that received SC.
- R6: A header that fails its check clears `st_seq_err`. Its SC is not used, and the expected count advances by one.
- R7: A pointer is present only when the header is valid, CI = 1 and SC is even (SC bit 4 = 0). Only then is `out_ptr` high, on the first payload octet, and `st_ptr_present` set.
- R8: The pointer octet holds bit 7 = parity and bits 6:0 = offset. `st_ptr_val` shows the offset, or 127 when no pointer is present. `st_ptr_err` is set if the octet's parity is odd, or if the offset is above 93 and is not 127.
- R9: A byte that has `in_sop` high is always taken as a header, even in the middle of a cell, and the abandoned cell produces no `out_last`. When no cell is in progress, bytes without `in_sop` are consumed and dropped.
- R10: All status pins are valid together with `out_last` and hold until the next header is taken. Their reset values are 0, except `st_ptr_val`, which resets to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_sop | input | 1 | Byte is the header of a new cell |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload octet valid |
| out_ready | input | 1 | Downstream accepts payload octet |
| out_data | output | 8 | Payload octet |
| out_ptr | output | 1 | Current octet is the pointer octet |
| out_last | output | 1 | Current octet is the last of the cell |
| st_hdr_ok | output | 1 | Header passed CRC and parity |
| st_seq_err | output | 1 | Sequence count discontinuity |
| st_ptr_present | output | 1 | Cell carries a pointer octet |
| st_ptr_err | output | 1 | Pointer parity or range error |
| st_ptr_val | output | 7 | Pointer offset (127 when absent) |

## Verification
The bench uses the default parameters: a 48-octet cell, an offset limit of 93 and 127 as the no-pointer code. With these values a full 47-octet payload passes through, and the boundary offsets 93, 94 and 127 can all be reached on real pointer octets. Within a few hundred cells, the count wraps through every residue modulo 8. Stimulus covers random stalls on both sides, skipped counts, CRC and parity faults, aborted cells and stray bytes before a start marker.

// File: rtl/aal1_sar_pkg.sv
`timescale 1ns/1ps
package aal1_sar_pkg;
  localparam int SEQ_W  = 3;
  localparam int CRC_W  = 3;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 7;

  typedef struct packed {
    logic             ci;
    logic [SEQ_W-1:0] sc;
    logic             ok;
  } hdr_info_t;
endpackage

// File: rtl/aal1_hdr_decode.sv
`timescale 1ns/1ps
module aal1_hdr_decode
  import aal1_sar_pkg::*;
(
  input  logic [BYTE_W-1:0] hdr_byte,
  output hdr_info_t         info
);
  // Serial CRC over CI and SC, MSB first, generator x^3 + x + 1.
  function automatic logic [CRC_W-1:0] crc_of(input logic [SEQ_W:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = SEQ_W; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return c;
  endfunction

  logic crc_match;
  logic par_even;

  always_comb begin
    crc_match = (crc_of(hdr_byte[7:4]) == hdr_byte[3:1]);
    par_even  = ~(^hdr_byte);
    info.ci   = hdr_byte[7];
    info.sc   = hdr_byte[6:4];
    info.ok   = crc_match & par_even;
  end
endmodule

// File: rtl/aal1_ptr_decode.sv
`timescale 1ns/1ps
module aal1_ptr_decode
  import aal1_sar_pkg::*;
#(
  parameter int OFF_MAX = 93,
  parameter int NO_PTR  = 127
) (
  input  logic [BYTE_W-1:0] ptr_byte,
  output logic [OFF_W-1:0]  offset,
  output logic              bad
);
  logic par_odd;
  logic out_of_range;

  always_comb begin
    offset       = ptr_byte[OFF_W-1:0];
    par_odd      = ^ptr_byte;
    out_of_range = (offset > OFF_W'(OFF_MAX)) && (offset != OFF_W'(NO_PTR));
    bad          = par_odd | out_of_range;
  end
endmodule

// File: rtl/aal1_seq_track.sv
`timescale 1ns/1ps
module aal1_seq_track
  import aal1_sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hdr_ok,
  input  logic [SEQ_W-1:0] sc,
  output logic             seq_err
);
  logic             have_ref_q;
  logic [SEQ_W-1:0] exp_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      exp_q      <= '0;
      err_q      <= 1'b0;
    end else if (take) begin
      if (hdr_ok) begin
        err_q      <= have_ref_q && (sc != exp_q);
        exp_q      <= sc + SEQ_W'(1);
        have_ref_q <= 1'b1;
      end else begin
        err_q <= 1'b0;
        exp_q <= exp_q + SEQ_W'(1);
      end
    end
  end

  assign seq_err = err_q;

  // R4: expectation follows the received count
  a_r4_expect_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hdr_ok) |=> (exp_q == $past(sc) + SEQ_W'(1)));

  // R6: a failed header never reports a discontinuity
  a_r6_bad_hdr_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hdr_ok) |=> !seq_err);
endmodule

// File: rtl/aal1_sar_rx.sv
`timescale 1ns/1ps
module aal1_sar_rx
  import aal1_sar_pkg::*;
#(
  parameter int CELL_BYTES = 48,
  parameter int OFF_MAX    = 93,
  parameter int NO_PTR     = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_ptr,
  output logic              out_last,
  output logic              st_hdr_ok,
  output logic              st_seq_err,
  output logic              st_ptr_present,
  output logic              st_ptr_err,
  output logic [OFF_W-1:0]  st_ptr_val
);
  localparam int POS_W    = $clog2(CELL_BYTES);
  localparam int LAST_POS = CELL_BYTES - 1;

  logic [POS_W-1:0] pos_q;
  logic             hdr_slot;
  logic             hdr_take;
  logic             sdu_take;
  logic             at_ptr;
  hdr_info_t        hinfo;
  logic [OFF_W-1:0] poff;
  logic             pbad;

  logic             hdr_ok_q;
  logic             ptr_pres_q;
  logic             ptr_err_q;
  logic [OFF_W-1:0] ptr_val_q;

  aal1_hdr_decode u_hdr (
    .hdr_byte (in_data),
    .info     (hinfo)
  );

  aal1_ptr_decode #(
    .OFF_MAX (OFF_MAX),
    .NO_PTR  (NO_PTR)
  ) u_ptr (
    .ptr_byte (in_data),
    .offset   (poff),
    .bad      (pbad)
  );

  aal1_seq_track u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (hdr_take),
    .hdr_ok  (hinfo.ok),
    .sc      (hinfo.sc),
    .seq_err (st_seq_err)
  );

  // Handshake: headers always accepted, payload passes through.
  assign hdr_slot  = in_sop || (pos_q == '0);
  assign in_ready  = hdr_slot | out_ready;
  assign out_valid = in_valid & ~hdr_slot;
  assign out_data  = in_data;
  assign out_last  = (pos_q == POS_W'(LAST_POS));
  assign at_ptr    = (pos_q == POS_W'(1)) & ptr_pres_q;
  assign out_ptr   = out_valid & at_ptr;
  assign hdr_take  = in_valid & in_sop;
  assign sdu_take  = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (hdr_take) begin
      pos_q <= POS_W'(1);
    end else if (sdu_take) begin
      pos_q <= out_last ? '0 : pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_ok_q   <= 1'b0;
      ptr_pres_q <= 1'b0;
      ptr_err_q  <= 1'b0;
      ptr_val_q  <= OFF_W'(NO_PTR);
    end else if (hdr_take) begin
      hdr_ok_q   <= hinfo.ok;
      ptr_pres_q <= hinfo.ok & hinfo.ci & ~hinfo.sc[0];
      ptr_err_q  <= 1'b0;
      ptr_val_q  <= OFF_W'(NO_PTR);
    end else if (sdu_take && at_ptr) begin
      ptr_err_q  <= pbad;
      ptr_val_q  <= poff;
    end
  end

  assign st_hdr_ok      = hdr_ok_q;
  assign st_ptr_present = ptr_pres_q;
  assign st_ptr_err     = ptr_err_q;
  assign st_ptr_val     = ptr_val_q;

  // R3: a stalled output stalls the input
  a_r3_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: the last payload octet returns the block to header hunt
  a_r2_last_returns_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (sdu_take && out_last) |=> (pos_q == '0));

  // R9: a start marker always opens a new cell
  a_r9_sop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> (pos_q == POS_W'(1)));

  // R7: pointer flag never on the last octet and never without a valid header
  a_r7_ptr_placement: assert property (@(posedge clk) disable iff (!rst_n)
    out_ptr |-> (out_valid && !out_last && st_hdr_ok));

  // R5: a discontinuity is only reported for a good header
  a_r5_err_needs_good_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    st_seq_err |-> st_hdr_ok);

  // R8: a pointer error needs a pointer
  a_r8_err_needs_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    st_ptr_err |-> st_ptr_present);
endmodule

// File: tb/aal1_sar_rx_tb.sv
`timescale 1ns/1ps
module aal1_sar_rx_tb;
  localparam int LAST = 47;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_ptr, out_last;
  logic [7:0] out_data;
  logic       st_hdr_ok, st_seq_err, st_ptr_present, st_ptr_err;
  logic [6:0] st_ptr_val;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit full_speed = 0;

  // reference model state
  int m_pos = 0, m_exp = 0, m_pval = 127;
  bit m_have = 0, m_ok = 0, m_err = 0, m_pp = 0, m_perr = 0;

  always #2.5 clk = ~clk;

  aal1_sar_rx u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ptr(out_ptr), .out_last(out_last),
    .st_hdr_ok(st_hdr_ok), .st_seq_err(st_seq_err), .st_ptr_present(st_ptr_present),
    .st_ptr_err(st_ptr_err), .st_ptr_val(st_ptr_val)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int crc_ref(input int d);
    int v = d << 3;
    for (int i = 6; i >= 3; i--)
      if (((v >> i) & 1) == 1) v = v ^ (11 << (i - 3));
    return v & 7;
  endfunction

  function automatic bit par_odd(input int b);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (b >> i) & 1;
    return bit'(c & 1);
  endfunction

  task automatic check_status(input string tag);
    chk({tag, " R1"}, "st_hdr_ok", st_hdr_ok, m_ok);
    chk({tag, " R4 R5"}, "st_seq_err", st_seq_err, m_err);
    chk({tag, " R7"}, "st_ptr_present", st_ptr_present, m_pp);
    chk({tag, " R8"}, "st_ptr_err", st_ptr_err, m_perr);
    chk({tag, " R8"}, "st_ptr_val", st_ptr_val, m_pval);
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] d, input bit r, output bit hs);
    bit hdr, er, ov;
    int sc;
    @(negedge clk);
    in_valid = v; in_sop = s; in_data = d; out_ready = r;
    #1;
    hdr = s || (m_pos == 0);
    er  = hdr ? 1'b1 : r;
    ov  = v && !hdr;
    chk("R3", "in_ready", in_ready, er);
    chk("R2 R9", "out_valid", out_valid, ov);
    if (ov) begin
      chk("R2", "out_data", out_data, d);
      chk("R7", "out_ptr", out_ptr, (m_pos == 1) && m_pp);
      chk("R2", "out_last", out_last, m_pos == LAST);
      if (m_pos == LAST) check_status("R10");
    end
    hs = v && er;
    if (hs) begin
      if (hdr) begin
        if (s) begin
          sc   = (d >> 4) & 7;
          m_ok = !par_odd(d) && (crc_ref((d >> 4) & 15) == ((d >> 1) & 7));
          if (m_ok) begin
            m_err  = m_have && (sc != m_exp);
            m_exp  = (sc + 1) % 8;
            m_have = 1;
          end else begin
            m_err = 0;
            m_exp = (m_exp + 1) % 8;
          end
          m_pp   = m_ok && d[7] && !d[4];
          m_perr = 0;
          m_pval = 127;
          m_pos  = 1;
        end
      end else begin
        if (m_pos == 1 && m_pp) begin
          m_pval = d[6:0];
          m_perr = par_odd(d) || (m_pval > 93 && m_pval != 127);
        end
        m_pos = (m_pos == LAST) ? 0 : m_pos + 1;
      end
    end
  endtask

  task automatic idle(input int n);
    bit hs;
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1, hs);
  endtask

  task automatic send_byte(input bit s, input logic [7:0] d);
    bit hs = 0, dummy;
    while (!hs) begin
      if (!full_speed && ($urandom % 4) == 0) step(0, 0, 8'h00, ($urandom % 2) == 0, dummy);
      step(1, s, d, full_speed ? 1'b1 : (($urandom % 3) != 0), hs);
    end
  endtask

  function automatic logic [7:0] mk_ptr(input int off, input bit bad);
    logic [6:0] o = off[6:0];
    return {(^o) ^ bad, o};
  endfunction

  task automatic send_cell(input bit ci, input int sc, input bit bad_crc, input bit bad_par,
                           input bit with_ptr, input logic [7:0] pb, input int nb);
    logic [7:0] h;
    h = {ci, sc[2:0], 3'(crc_ref({28'd0, ci, sc[2:0]})), 1'b0};
    h[0] = ^h[7:1];
    if (bad_crc) begin h[1] = ~h[1]; h[0] = ^h[7:1]; end
    if (bad_par) h[0] = ~h[0];
    send_byte(1, h);
    for (int k = 1; k <= nb; k++)
      send_byte(0, (k == 1 && with_ptr) ? pb : 8'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int offs[6] = '{0, 93, 127, 94, 50, 5};
    repeat (3) @(posedge clk);
    // R10 reset state
    @(negedge clk); #1;
    check_status("R10 reset");
    chk("R3 reset", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    idle(2);

    // in-order cells, pointers on even counts with CI set (R4 R7 R8)
    for (int i = 0; i < 12; i++) begin
      bit even = (i % 2) == 0;
      send_cell(even, i % 8, 0, 0, even, mk_ptr(offs[(i / 2) % 6], (i % 12) == 8), LAST);
    end
    idle(1); check_status("R10 hold");

    // skipped count: expected 4, send 6 then 7 (R5)
    send_cell(1, 6, 0, 0, 1, mk_ptr(10, 0), LAST);
    idle(1); chk("R5", "skip flagged", st_seq_err, 1);
    send_cell(0, 7, 0, 0, 0, 8'h00, LAST);
    idle(1); chk("R5", "resync", st_seq_err, 0);

    // CRC fault then continuation (R1 R6)
    send_cell(1, 0, 1, 0, 0, 8'h00, LAST);
    idle(1); chk("R1", "crc fault", st_hdr_ok, 0); chk("R6", "no seq err", st_seq_err, 0);
    chk("R7", "no ptr on bad hdr", st_ptr_present, 0);
    send_cell(0, 1, 0, 0, 0, 8'h00, LAST);
    idle(1); chk("R6", "expected advanced", st_seq_err, 0);

    // parity fault (R1)
    send_cell(0, 2, 0, 1, 0, 8'h00, LAST);
    idle(1); chk("R1", "parity fault", st_hdr_ok, 0);

    // odd count with CI, even count without CI: no pointer (R7)
    send_cell(1, 3, 0, 0, 0, 8'h00, LAST);
    idle(1); chk("R7", "odd sc no ptr", st_ptr_present, 0);
    send_cell(0, 4, 0, 0, 0, 8'h00, LAST);
    idle(1); chk("R7", "ci clear no ptr", st_ptr_present, 0);

    // aborted cell, stray bytes, restart (R9)
    send_cell(0, 5, 0, 0, 0, 8'h00, 10);
    send_cell(1, 6, 0, 0, 1, mk_ptr(127, 0), LAST);
    send_byte(0, 8'hA5); send_byte(0, 8'h5A);
    idle(1); chk("R9", "stray dropped", out_valid, 0);
    send_cell(0, 7, 0, 0, 0, 8'h00, LAST);
    idle(1); chk("R9", "continuity after abort", st_seq_err, 0);

    // full-rate run with wraparound
    full_speed = 1;
    for (int i = 0; i < 10; i++)
      send_cell((i % 2) == 0, i % 8, 0, 0, (i % 2) == 0, mk_ptr(i * 9, 0), LAST);
    full_speed = 0;
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule